// File: doc/BRIEF.md
# Software-Refilled Fully Associative Translation Buffer

This block translates 32-bit virtual addresses into 32-bit physical addresses for 4 KB pages. The upper 20 bits of a request address are the virtual page number. The low 12 bits are the page offset. Each request is compared against every stored entry at once, and the answer is produced in the same cycle as the request. A hit joins the stored physical page number with the unchanged offset to form the physical address.

The block never fetches a missing translation by itself. On a miss, or on a write to a page that does not permit writes, it raises an exception and latches the faulting page number into a register that stays readable. The handler then installs a translation through a load port. That port writes one slot, chosen by index, with a tag, a physical page number and status bits. A permitted write hit marks its entry dirty, so the page can be written back when the entry is replaced.

Top module: `va_xlate_tlb`

## Requirements
- R1: On a hit, `resp_paddr_o` equals the matched 20-bit physical page number in bits 31:12 and the request's bits 11:0 in bits 11:0, in the same cycle as the request. When there is no hit, `resp_paddr_o` is zero.
- R2: The lookup is fully associative. A translation loaded into any of the 64 slots (index 0 to 63) can produce a hit for its tag.
- R3: Only entries whose valid bit is set can hit. After reset every entry is invalid and `fault_vpn_o` is zero.
- R4: A valid request that matches no valid entry asserts `miss_exc_o` in the same cycle. From the next cycle on, `fault_vpn_o` holds the request's bits 31:12.
- R5: A load with `ld_en_i` high writes the slot at `ld_idx_i` with the given tag, physical page number, valid, dirty and write-permission bits. The new contents take effect from the next clock edge, so a lookup in the cycle of the load still sees the old contents.
- R6: A write request that hits an entry whose write-permission bit is clear asserts `prot_exc_o` and keeps `resp_hit_o` low and `resp_paddr_o` zero. From the next cycle on, `fault_vpn_o` holds the request's page number.
- R7: A write that hits a writable entry sets that entry's dirty bit at the next edge. Read hits leave the dirty bit unchanged. On every hit, `resp_dirty_o` reports the matched entry's current dirty bit; without a hit it is zero.
- R8: `flush_i` clears every valid bit at the next edge. If a load arrives in the same cycle, the flush takes priority and the loaded slot ends up invalid.
- R9: If more than one valid entry matches a valid request, the lowest-numbered entry supplies the result and `multi_match_o` is high in that cycle. With one or no match, `multi_match_o` is low.
- R10: `fault_vpn_o` changes only on a miss or a protection fault. Hits, idle cycles, loads and flushes leave it unchanged.
- R11: When `req_valid_i` is low, `resp_hit_o`, `miss_exc_o`, `prot_exc_o` and `multi_match_o` are all low, and no dirty bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Lookup request present |
| req_write_i | input | 1 | Request is a write |
| req_vaddr_i | input | 32 | Virtual address of the request |
| resp_hit_o | output | 1 | Translation succeeded |
| resp_paddr_o | output | 32 | Translated physical address |
| resp_dirty_o | output | 1 | Dirty bit of the matched entry |
| miss_exc_o | output | 1 | Miss exception |
| prot_exc_o | output | 1 | Write-protection exception |
| multi_match_o | output | 1 | More than one valid entry matched |
| fault_vpn_o | output | 20 | Page number of the last fault |
| ld_en_i | input | 1 | Software load strobe |
| ld_idx_i | input | 6 | Slot to load |
| ld_vtag_i | input | 20 | Virtual page tag to load |
| ld_ppn_i | input | 20 | Physical page number to load |
| ld_valid_i | input | 1 | Valid bit to load |
| ld_dirty_i | input | 1 | Dirty bit to load |
| ld_wperm_i | input | 1 | Write-permission bit to load |

## Verification
A wrong entry, such as a corrupted tag, page number or status bit, shows up only when a request names that entry's page. From then on, every lookup to that page returns a wrong hit, address, dirty report or exception in the same cycle. A lost dirty update or a missed flush appears on the first later lookup of the affected page. A faulty fault register is visible on `fault_vpn_o` one cycle after the exception, or as a drift during cycles without a fault. For these reasons, the bench keeps a full shadow of all 64 entries and compares every output on every cycle, including idle ones.

// File: rtl/xtlb_pkg.sv
// Shared constants and entry layout for the translation buffer.
// Assumes 32-bit virtual and physical addresses with 4 KB pages.
package xtlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFS_W  = 12;
    localparam int VPN_W  = VA_W - OFS_W;
    localparam int PPN_W  = 20;
    localparam int PA_W   = PPN_W + OFS_W;
    localparam int N_ENT  = 64;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic             wperm;
        logic [VPN_W-1:0] vtag;
        logic [PPN_W-1:0] ppn;
    } xtlb_entry_t;
endpackage

// File: rtl/xtlb_entry_array.sv
// Entry storage: one register set per slot.
// Per slot, the update order is: reset, then flush (clears valid), then
// software load, then dirty-set. Assumes at most one load and one
// dirty-set per cycle.
module xtlb_entry_array
    import xtlb_pkg::*;
#(
    parameter int NUM = N_ENT,
    localparam int IW = $clog2(NUM)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush_i,
    input  logic        ld_en_i,
    input  logic [IW-1:0] ld_idx_i,
    input  xtlb_entry_t ld_entry_i,
    input  logic        dset_en_i,
    input  logic [IW-1:0] dset_idx_i,
    output xtlb_entry_t entries_o [NUM]
);
    for (genvar g = 0; g < NUM; g++) begin : g_slot
        xtlb_entry_t slot_q;

        // Slot register: reset, flush, load and dirty update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (flush_i) begin
                slot_q.valid <= 1'b0;
            end else if (ld_en_i && (ld_idx_i == IW'(g))) begin
                slot_q <= ld_entry_i;
            end else if (dset_en_i && (dset_idx_i == IW'(g))) begin
                slot_q.dirty <= 1'b1;
            end
        end

        assign entries_o[g] = slot_q;
    end
endmodule

// File: rtl/xtlb_match_sel.sv
// Parallel tag compare across all slots with a lowest-index select.
// Purely combinational. Only valid slots take part in the compare.
module xtlb_match_sel
    import xtlb_pkg::*;
#(
    parameter int NUM = N_ENT,
    localparam int IW = $clog2(NUM)
) (
    input  xtlb_entry_t       entries_i [NUM],
    input  logic [VPN_W-1:0]  vpn_i,
    output logic              any_o,
    output logic              multi_o,
    output logic [IW-1:0]     sel_idx_o,
    output xtlb_entry_t       sel_entry_o
);
    logic [NUM-1:0] hit_vec;

    // Per-slot compare of the valid bit and the tag
    always_comb begin
        for (int i = 0; i < NUM; i++) begin
            hit_vec[i] = entries_i[i].valid && (entries_i[i].vtag == vpn_i);
        end
    end

    // Priority encode: scanning downward, the lowest matching index is assigned last
    always_comb begin
        sel_idx_o = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel_idx_o = IW'(i);
        end
    end

    assign any_o       = |hit_vec;
    assign multi_o     = ($countones(hit_vec) > 1);
    assign sel_entry_o = entries_i[sel_idx_o];
endmodule

// File: rtl/xtlb_fault_reg.sv
// Holds the page number of the most recent miss or protection fault.
// Reset value is zero.
module xtlb_fault_reg
    import xtlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic [VPN_W-1:0] vpn_i,
    output logic [VPN_W-1:0] vpn_o
);
    // Capture on a fault, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)     vpn_o <= '0;
        else if (cap_i) vpn_o <= vpn_i;
    end
endmodule

// File: rtl/va_xlate_tlb.sv
// Top level of the software-refilled, fully associative translation buffer.
// The lookup is combinational (same-cycle response). Misses and denied
// writes raise exceptions and latch the faulting page number. Entries
// change only through the load port, a flush, or a dirty-set on a
// permitted write hit.
module va_xlate_tlb
    import xtlb_pkg::*;
#(
    parameter int NUM = N_ENT,
    localparam int IW = $clog2(NUM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic [VA_W-1:0]  req_vaddr_i,
    output logic             resp_hit_o,
    output logic [PA_W-1:0]  resp_paddr_o,
    output logic             resp_dirty_o,
    output logic             miss_exc_o,
    output logic             prot_exc_o,
    output logic             multi_match_o,
    output logic [VPN_W-1:0] fault_vpn_o,
    input  logic             ld_en_i,
    input  logic [IW-1:0]    ld_idx_i,
    input  logic [VPN_W-1:0] ld_vtag_i,
    input  logic [PPN_W-1:0] ld_ppn_i,
    input  logic             ld_valid_i,
    input  logic             ld_dirty_i,
    input  logic             ld_wperm_i
);
    xtlb_entry_t      entries [NUM];
    xtlb_entry_t      ld_entry;
    xtlb_entry_t      sel_entry;
    logic [IW-1:0]    sel_idx;
    logic             any_match;
    logic             multi;
    logic [VPN_W-1:0] req_vpn;
    logic [OFS_W-1:0] req_ofs;
    logic             found;
    logic             denied;
    logic             grant;

    assign req_vpn = req_vaddr_i[VA_W-1:OFS_W];
    assign req_ofs = req_vaddr_i[OFS_W-1:0];

    // Assemble the load-port fields into one entry
    always_comb begin
        ld_entry       = '0;
        ld_entry.valid = ld_valid_i;
        ld_entry.dirty = ld_dirty_i;
        ld_entry.wperm = ld_wperm_i;
        ld_entry.vtag  = ld_vtag_i;
        ld_entry.ppn   = ld_ppn_i;
    end

    xtlb_entry_array #(.NUM(NUM)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .ld_en_i    (ld_en_i),
        .ld_idx_i   (ld_idx_i),
        .ld_entry_i (ld_entry),
        .dset_en_i  (grant && req_write_i),
        .dset_idx_i (sel_idx),
        .entries_o  (entries)
    );

    xtlb_match_sel #(.NUM(NUM)) u_match (
        .entries_i   (entries),
        .vpn_i       (req_vpn),
        .any_o       (any_match),
        .multi_o     (multi),
        .sel_idx_o   (sel_idx),
        .sel_entry_o (sel_entry)
    );

    // Classify the request: granted hit, denied write, or miss
    always_comb begin
        found  = req_valid_i && any_match;
        denied = found && req_write_i && !sel_entry.wperm;
        grant  = found && !denied;
    end

    xtlb_fault_reg u_fault (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_i (miss_exc_o || prot_exc_o),
        .vpn_i (req_vpn),
        .vpn_o (fault_vpn_o)
    );

    // Drive the response outputs
    always_comb begin
        resp_hit_o    = grant;
        resp_paddr_o  = grant ? {sel_entry.ppn, req_ofs} : '0;
        resp_dirty_o  = grant && sel_entry.dirty;
        miss_exc_o    = req_valid_i && !any_match;
        prot_exc_o    = denied;
        multi_match_o = req_valid_i && multi;
    end
endmodule

// File: rtl/xtlb_chk.sv
// Property checker for va_xlate_tlb, attached through bind below.
module xtlb_chk
    import xtlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             flush_i,
    input logic             ld_en_i,
    input logic             req_valid_i,
    input logic [VA_W-1:0]  req_vaddr_i,
    input logic             resp_hit_o,
    input logic [PA_W-1:0]  resp_paddr_o,
    input logic             miss_exc_o,
    input logic             prot_exc_o,
    input logic             multi_match_o,
    input logic [VPN_W-1:0] fault_vpn_o
);
    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit_o |-> resp_paddr_o[OFS_W-1:0] == req_vaddr_i[OFS_W-1:0]);

    // R4
    miss_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_exc_o |=> fault_vpn_o == $past(req_vaddr_i[VA_W-1:OFS_W]));

    // R6
    deny_no_xlate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_exc_o |-> (!resp_hit_o && resp_paddr_o == '0 && !miss_exc_o));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!resp_hit_o && !prot_exc_o && !multi_match_o));

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_exc_o && !prot_exc_o) |=> $stable(fault_vpn_o));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |-> !(resp_hit_o || miss_exc_o || prot_exc_o || multi_match_o));
endmodule

bind va_xlate_tlb xtlb_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .ld_en_i       (ld_en_i),
    .req_valid_i   (req_valid_i),
    .req_vaddr_i   (req_vaddr_i),
    .resp_hit_o    (resp_hit_o),
    .resp_paddr_o  (resp_paddr_o),
    .miss_exc_o    (miss_exc_o),
    .prot_exc_o    (prot_exc_o),
    .multi_match_o (multi_match_o),
    .fault_vpn_o   (fault_vpn_o)
);

// File: tb/sim_va_xlate_tlb.sv
// Bench: a shadow model of all slots, directed corner cases, then
// seeded random traffic. Every output is compared on every step.
module sim_va_xlate_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [31:0] req_vaddr_i = '0;
    logic        resp_hit_o, resp_dirty_o, miss_exc_o, prot_exc_o, multi_match_o;
    logic [31:0] resp_paddr_o;
    logic [19:0] fault_vpn_o;
    logic        ld_en_i = 1'b0;
    logic [5:0]  ld_idx_i = '0;
    logic [19:0] ld_vtag_i = '0;
    logic [19:0] ld_ppn_i = '0;
    logic        ld_valid_i = 1'b0, ld_dirty_i = 1'b0, ld_wperm_i = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    // Shadow model of the slots and the fault register
    logic [19:0] m_tag [64];
    logic [19:0] m_ppn [64];
    logic        m_v [64];
    logic        m_d [64];
    logic        m_w [64];
    logic [19:0] m_fault;

    always #10 clk = ~clk;

    va_xlate_tlb u0 (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) begin
            m_tag[i] = '0; m_ppn[i] = '0; m_v[i] = 0; m_d[i] = 0; m_w[i] = 0;
        end
        m_fault = '0;
    endtask

    // One cycle: drive at negedge, check mid-cycle, then advance the model
    task automatic step(input string tag, input bit rv, input bit wr, input logic [31:0] va,
                        input bit fl, input bit le, input int li, input logic [19:0] lt,
                        input logic [19:0] lp, input bit lv, input bit ld, input bit lw);
        int  sel, cnt;
        bit  e_hit, e_miss, e_prot;
        logic [31:0] e_pa;
        @(negedge clk);
        req_valid_i = rv; req_write_i = wr; req_vaddr_i = va; flush_i = fl;
        ld_en_i = le; ld_idx_i = 6'(li); ld_vtag_i = lt; ld_ppn_i = lp;
        ld_valid_i = lv; ld_dirty_i = ld; ld_wperm_i = lw;
        #5;
        sel = -1; cnt = 0;
        for (int i = 63; i >= 0; i--)
            if (m_v[i] && m_tag[i] == va[31:12]) begin sel = i; cnt++; end
        e_miss = rv && (cnt == 0);
        e_prot = rv && (cnt > 0) && wr && !m_w[sel];
        e_hit  = rv && (cnt > 0) && !e_prot;
        e_pa   = e_hit ? {m_ppn[sel], va[11:0]} : 32'h0;
        chk({tag, " hit"},   32'(resp_hit_o), 32'(e_hit));
        chk({tag, " paddr"}, resp_paddr_o, e_pa);
        chk({tag, " dirty"}, 32'(resp_dirty_o), 32'(e_hit && m_d[sel]));
        chk({tag, " miss"},  32'(miss_exc_o), 32'(e_miss));
        chk({tag, " prot"},  32'(prot_exc_o), 32'(e_prot));
        chk({tag, " multi"}, 32'(multi_match_o), 32'(rv && cnt > 1));
        chk({tag, " fault"}, 32'(fault_vpn_o), 32'(m_fault));
        if (e_miss || e_prot) m_fault = va[31:12];
        if (fl) begin
            for (int i = 0; i < 64; i++) m_v[i] = 0;
        end else begin
            if (e_hit && wr) m_d[sel] = 1;
            if (le) begin
                m_tag[li] = lt; m_ppn[li] = lp; m_v[li] = lv; m_d[li] = ld; m_w[li] = lw;
            end
        end
    endtask

    task automatic look(string tag, bit wr, logic [31:0] va);
        step(tag, 1, wr, va, 0, 0, 0, '0, '0, 0, 0, 0);
    endtask

    task automatic load(string tag, int idx, logic [19:0] t, logic [19:0] p, bit v, bit d, bit w);
        step(tag, 0, 0, '0, 0, 1, idx, t, p, v, d, w);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [31:0] va;
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R3: reset state, everything misses
        chk("R3 fault after reset", 32'(fault_vpn_o), 32'h0);
        step("R3 idle", 0, 0, 32'h0, 0, 0, 0, '0, '0, 0, 0, 0);
        look("R3 miss after reset", 0, 32'h0000_0123);
        // R4: fault register captures page number
        look("R4 miss", 0, 32'hABCDE_456);
        look("R4 capture", 0, 32'h12345_000);
        // R2, R5: far slots, load visible next edge, same-cycle lookup sees old contents
        load("R2 load slot 63", 63, 20'h12345, 20'h0BEEF, 1, 0, 1);
        step("R5 load slot 0 same-cycle", 1, 0, 32'h22222_777, 0, 1, 0, 20'h22222, 20'h00A0A, 1, 0, 0);
        look("R1 R2 hit slot 0", 0, 32'h22222_777);
        look("R1 R2 hit slot 63", 0, 32'h12345_FFF);
        // R6: write to read-only entry
        look("R6 denied write", 1, 32'h22222_010);
        look("R10 hold after hit", 0, 32'h12345_001);
        // R7: permitted write sets dirty, read does not
        look("R7 read clean", 0, 32'h12345_002);
        look("R7 write hit", 1, 32'h12345_003);
        look("R7 dirty visible", 0, 32'h12345_004);
        // R3: invalid entry never hits
        load("R3 invalid load", 5, 20'h33333, 20'h00001, 0, 0, 1);
        look("R3 invalid miss", 0, 32'h33333_000);
        // R9: multiple matches pick lowest index
        load("R9 load 40", 40, 20'h44444, 20'h00040, 1, 0, 1);
        load("R9 load 7", 7, 20'h44444, 20'h00007, 1, 1, 0);
        look("R9 multi read", 0, 32'h44444_ABC);
        look("R9 multi write lowest denied", 1, 32'h44444_ABC);
        // R11: idle does nothing
        step("R11 idle", 0, 1, 32'h44444_000, 0, 0, 0, '0, '0, 0, 0, 0);
        // R8: flush beats same-cycle load
        step("R8 flush with load", 0, 0, '0, 1, 1, 9, 20'h55555, 20'h00009, 1, 0, 1);
        look("R8 after flush 63", 0, 32'h12345_000);
        look("R8 loaded slot invalid", 0, 32'h55555_000);
        // Random traffic from a small tag pool to provoke multi-matches
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom % 100);
            va = {20'h60000 + 20'($urandom % 8), 12'($urandom)};
            if (r < 2)
                step("R8 rnd flush", 0, 0, '0, 1, 0, 0, '0, '0, 0, 0, 0);
            else if (r < 30)
                step("R5 rnd load", ($urandom % 2) == 1, ($urandom % 2) == 1, va, 0, 1,
                     int'($urandom % 64), 20'h60000 + 20'($urandom % 8), 20'($urandom),
                     ($urandom % 8) != 0, ($urandom % 2) == 1, ($urandom % 2) == 1);
            else if (r < 35)
                step("R11 rnd idle", 0, ($urandom % 2) == 1, va, 0, 0, 0, '0, '0, 0, 0, 0);
            else
                look("R9 rnd lookup", ($urandom % 3) == 0, va);
        end
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule